// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the four status flags of a small 8-bit processor core: the interrupt-enable flag, the zero flag, the half (auxiliary) carry flag and the carry flag. Each cycle it takes the ALU result byte, the carry, half-carry and shift-out bits that the ALU produced, and a code naming the class of the operation. It then updates only those flags that this class affects and that the decoder has enabled. The carry flag has three uses. It holds the carry or borrow of arithmetic, it takes the bit shifted out by a rotate, and it serves as a one-bit accumulator for bit-manipulation instructions.

The interrupt-enable flag is driven by disable and enable strobes from the instruction decoder and by the interrupt acknowledge from the interrupt controller. An acknowledge always turns interrupts off. The flags are also presented as one packed status byte, and that byte can be loaded back in a single cycle when a saved status is restored. Reset is asynchronous and active low. Its release is synchronised to the clock inside the block.

Top module: `cpu_status_flags`

## Requirements
- R1: While reset is asserted, and after it is released until an update occurs, all four flags and the whole status byte read 0. Asserting reset clears them without waiting for a clock edge.
- R2: With op_class 1 (add/subtract) or 4 (logical) and wen_z high, the zero flag becomes 1 if alu_res is 0x00 and becomes 0 otherwise.
- R3: With op_class 1 and wen_ac high, the half-carry flag takes alu_half, which is the carry out of bit 3 or the borrow into bit 3.
- R4: With op_class 1 and wen_cy high, the carry flag takes alu_carry.
- R5: With op_class 2 (rotate) and wen_cy high, the carry flag takes alu_rot_out. The zero and half-carry flags are untouched.
- R6: With op_class 3 (bit operation) and wen_cy high, the carry flag is set by bit_fn. The codes are 0 load bit_in, 1 AND bit_in, 2 OR bit_in, 3 XOR bit_in, 4 set, 5 clear, 6 complement, and 7 keep (store carry elsewhere).
- R7: A flag holds its value when its write enable is low, when op_class is 0 or an unused code (5 to 7), or when the class does not affect it. Logical operations leave half-carry and carry alone. Bit operations leave zero and half-carry alone.
- R8: ei_stb sets the interrupt-enable flag and di_stb clears it. If both arrive together, disable wins.
- R9: ack_stb clears the interrupt-enable flag in the next cycle, even when ei_stb or a status restore is present in the same cycle.
- R10: status_byte carries interrupt enable in bit 7, zero in bit 6, half carry in bit 4 and carry in bit 0. All other bits read 0, and each bit equals its individual flag output.
- R11: restore_en loads the flags from restore_byte, using the bit positions of R10 and ignoring the other bits. It takes priority over every ALU update and over the disable and enable strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_class | input | 3 | Operation class: 0 none, 1 add/sub, 2 rotate, 3 bit op, 4 logical |
| bit_fn | input | 3 | Carry accumulator function for bit operations |
| alu_res | input | 8 | ALU result byte |
| alu_carry | input | 1 | Carry/borrow out of the MSB |
| alu_half | input | 1 | Carry out of / borrow into bit 3 |
| alu_rot_out | input | 1 | Bit shifted out by a rotate |
| bit_in | input | 1 | Operand bit for bit operations |
| wen_z | input | 1 | Zero flag write enable |
| wen_ac | input | 1 | Half-carry flag write enable |
| wen_cy | input | 1 | Carry flag write enable |
| di_stb | input | 1 | Disable-interrupts strobe |
| ei_stb | input | 1 | Enable-interrupts strobe |
| ack_stb | input | 1 | Interrupt acknowledge strobe |
| restore_en | input | 1 | Load flags from restore_byte |
| restore_byte | input | 8 | Saved status byte |
| flag_ie | output | 1 | Interrupt enable flag |
| flag_z | output | 1 | Zero flag |
| flag_ac | output | 1 | Half-carry flag |
| flag_cy | output | 1 | Carry flag |
| status_byte | output | 8 | Packed flags |

## Verification
The properties assume that every input is a clean, clock-synchronous level that is valid at each rising edge. They also assume that nothing but zeros is applied while the synchronised reset is still low, so they are disabled until the internal reset release. The bench changes every input only on the falling clock edge and keeps all strobes and enables at zero across each reset. Unused op_class codes are driven on purpose, because they are a defined case under the hold rule.

// File: rtl/stflg_pkg.sv
package stflg_pkg;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ARITH = 3'd1,
    OPC_ROT   = 3'd2,
    OPC_BIT   = 3'd3,
    OPC_LOGIC = 3'd4
  } op_class_e;

  typedef enum logic [2:0] {
    BF_LOAD = 3'd0,
    BF_AND  = 3'd1,
    BF_OR   = 3'd2,
    BF_XOR  = 3'd3,
    BF_SET  = 3'd4,
    BF_CLR  = 3'd5,
    BF_INV  = 3'd6,
    BF_KEEP = 3'd7
  } bit_fn_e;

  typedef struct packed {
    logic ie;
    logic z;
    logic ac;
    logic cy;
  } flags_t;

endpackage

// File: rtl/stflg_rst_sync.sv
module stflg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/stflg_bitacc.sv
module stflg_bitacc
  import stflg_pkg::*;
(
  input  bit_fn_e fn,
  input  logic    cy_q,
  input  logic    bit_in,
  output logic    cy_d
);
  always_comb begin
    case (fn)
      BF_LOAD: cy_d = bit_in;
      BF_AND:  cy_d = cy_q & bit_in;
      BF_OR:   cy_d = cy_q | bit_in;
      BF_XOR:  cy_d = cy_q ^ bit_in;
      BF_SET:  cy_d = 1'b1;
      BF_CLR:  cy_d = 1'b0;
      BF_INV:  cy_d = ~cy_q;
      default: cy_d = cy_q;
    endcase
  end
endmodule

// File: rtl/stflg_alu_next.sv
module stflg_alu_next
  import stflg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_class_e         cls,
  input  bit_fn_e           fn,
  input  logic [DATA_W-1:0] res,
  input  logic              carry,
  input  logic              half,
  input  logic              rot_out,
  input  logic              bit_in,
  input  logic              wen_z,
  input  logic              wen_ac,
  input  logic              wen_cy,
  input  logic              z_q,
  input  logic              ac_q,
  input  logic              cy_q,
  output logic              z_d,
  output logic              ac_d,
  output logic              cy_d
);
  localparam logic [DATA_W-1:0] ALL_ZERO = '0;

  logic acc_cy;
  logic res_zero;

  assign res_zero = (res == ALL_ZERO);

  stflg_bitacc u_bitacc (
    .fn     (fn),
    .cy_q   (cy_q),
    .bit_in (bit_in),
    .cy_d   (acc_cy)
  );

  always_comb begin
    z_d  = z_q;
    ac_d = ac_q;
    cy_d = cy_q;
    case (cls)
      OPC_ARITH: begin
        if (wen_z)  z_d  = res_zero;
        if (wen_ac) ac_d = half;
        if (wen_cy) cy_d = carry;
      end
      OPC_LOGIC: begin
        if (wen_z)  z_d  = res_zero;
      end
      OPC_ROT: begin
        if (wen_cy) cy_d = rot_out;
      end
      OPC_BIT: begin
        if (wen_cy) cy_d = acc_cy;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stflg_ie_next.sv
module stflg_ie_next (
  input  logic ie_q,
  input  logic di_stb,
  input  logic ei_stb,
  input  logic ack_stb,
  input  logic load_en,
  input  logic load_ie,
  output logic ie_d
);
  always_comb begin
    if (ack_stb)      ie_d = 1'b0;
    else if (load_en) ie_d = load_ie;
    else if (di_stb)  ie_d = 1'b0;
    else if (ei_stb)  ie_d = 1'b1;
    else              ie_d = ie_q;
  end
endmodule

// File: rtl/cpu_status_flags.sv
module cpu_status_flags
  import stflg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int STAT_W      = 8,
  parameter int POS_IE      = 7,
  parameter int POS_Z       = 6,
  parameter int POS_AC      = 4,
  parameter int POS_CY      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_class,
  input  logic [2:0]        bit_fn,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              alu_half,
  input  logic              alu_rot_out,
  input  logic              bit_in,
  input  logic              wen_z,
  input  logic              wen_ac,
  input  logic              wen_cy,
  input  logic              di_stb,
  input  logic              ei_stb,
  input  logic              ack_stb,
  input  logic              restore_en,
  input  logic [STAT_W-1:0] restore_byte,
  output logic              flag_ie,
  output logic              flag_z,
  output logic              flag_ac,
  output logic              flag_cy,
  output logic [STAT_W-1:0] status_byte
);
  logic   rst_sync_n;
  flags_t flags_q;
  flags_t flags_d;
  logic   z_alu, ac_alu, cy_alu;
  logic   ie_nxt;
  logic   upd_en;
  logic   unused_restore_bits;

  assign unused_restore_bits = ^restore_byte;

  stflg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stflg_alu_next #(.DATA_W(DATA_W)) u_alu_next (
    .cls     (op_class_e'(op_class)),
    .fn      (bit_fn_e'(bit_fn)),
    .res     (alu_res),
    .carry   (alu_carry),
    .half    (alu_half),
    .rot_out (alu_rot_out),
    .bit_in  (bit_in),
    .wen_z   (wen_z),
    .wen_ac  (wen_ac),
    .wen_cy  (wen_cy),
    .z_q     (flags_q.z),
    .ac_q    (flags_q.ac),
    .cy_q    (flags_q.cy),
    .z_d     (z_alu),
    .ac_d    (ac_alu),
    .cy_d    (cy_alu)
  );

  stflg_ie_next u_ie_next (
    .ie_q    (flags_q.ie),
    .di_stb  (di_stb),
    .ei_stb  (ei_stb),
    .ack_stb (ack_stb),
    .load_en (restore_en),
    .load_ie (restore_byte[POS_IE]),
    .ie_d    (ie_nxt)
  );

  // next state: restore overrides ALU results
  always_comb begin
    flags_d.ie = ie_nxt;
    if (restore_en) begin
      flags_d.z  = restore_byte[POS_Z];
      flags_d.ac = restore_byte[POS_AC];
      flags_d.cy = restore_byte[POS_CY];
    end else begin
      flags_d.z  = z_alu;
      flags_d.ac = ac_alu;
      flags_d.cy = cy_alu;
    end
    upd_en = (flags_d != flags_q);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  flags_q <= '0;
    else if (upd_en)  flags_q <= flags_d;
  end

  assign flag_ie = flags_q.ie;
  assign flag_z  = flags_q.z;
  assign flag_ac = flags_q.ac;
  assign flag_cy = flags_q.cy;

  always_comb begin
    status_byte         = '0;
    status_byte[POS_IE] = flags_q.ie;
    status_byte[POS_Z]  = flags_q.z;
    status_byte[POS_AC] = flags_q.ac;
    status_byte[POS_CY] = flags_q.cy;
  end
endmodule

// File: rtl/stflg_checker.sv
module stflg_checker
  import stflg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8,
  parameter int POS_IE = 7,
  parameter int POS_Z  = 6,
  parameter int POS_AC = 4,
  parameter int POS_CY = 0
) (
  input logic              clk,
  input logic              rst_ok,
  input logic [2:0]        op_class,
  input logic [DATA_W-1:0] alu_res,
  input logic              alu_half,
  input logic              alu_rot_out,
  input logic              wen_z,
  input logic              wen_ac,
  input logic              wen_cy,
  input logic              di_stb,
  input logic              ei_stb,
  input logic              ack_stb,
  input logic              restore_en,
  input logic [STAT_W-1:0] restore_byte,
  input logic              flag_ie,
  input logic              flag_z,
  input logic              flag_ac,
  input logic              flag_cy
);
  localparam logic [DATA_W-1:0] ALL_ZERO = '0;

  logic cls_zero_upd, cls_idle;
  assign cls_zero_upd = (op_class == OPC_ARITH) || (op_class == OPC_LOGIC);
  assign cls_idle     = (op_class == OPC_NONE) || (op_class > OPC_LOGIC);

  // R9
  a_r9_ack_clears_ie: assert property (@(posedge clk) disable iff (!rst_ok)
    ack_stb |=> !flag_ie);

  // R8
  a_r8_ei_sets_ie: assert property (@(posedge clk) disable iff (!rst_ok)
    (ei_stb && !di_stb && !ack_stb && !restore_en) |=> flag_ie);

  // R8
  a_r8_di_clears_ie: assert property (@(posedge clk) disable iff (!rst_ok)
    (di_stb && !ack_stb && !restore_en) |=> !flag_ie);

  // R2
  a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rst_ok)
    (cls_zero_upd && wen_z && !restore_en) |=> (flag_z == ($past(alu_res) == ALL_ZERO)));

  // R3
  a_r3_half_carry: assert property (@(posedge clk) disable iff (!rst_ok)
    ((op_class == OPC_ARITH) && wen_ac && !restore_en) |=> (flag_ac == $past(alu_half)));

  // R5
  a_r5_rotate_carry: assert property (@(posedge clk) disable iff (!rst_ok)
    ((op_class == OPC_ROT) && wen_cy && !restore_en) |=> (flag_cy == $past(alu_rot_out)));

  // R7
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (cls_idle && !restore_en) |=> ($stable(flag_z) && $stable(flag_ac) && $stable(flag_cy)));

  // R11
  a_r11_restore: assert property (@(posedge clk) disable iff (!rst_ok)
    restore_en |=> (flag_z == $past(restore_byte[POS_Z]) &&
                    flag_ac == $past(restore_byte[POS_AC]) &&
                    flag_cy == $past(restore_byte[POS_CY])));

  // R11
  a_r11_restore_ie: assert property (@(posedge clk) disable iff (!rst_ok)
    (restore_en && !ack_stb) |=> (flag_ie == $past(restore_byte[POS_IE])));
endmodule

bind cpu_status_flags stflg_checker #(
  .DATA_W (DATA_W),
  .STAT_W (STAT_W),
  .POS_IE (POS_IE),
  .POS_Z  (POS_Z),
  .POS_AC (POS_AC),
  .POS_CY (POS_CY)
) u_stflg_checker (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .op_class     (op_class),
  .alu_res      (alu_res),
  .alu_half     (alu_half),
  .alu_rot_out  (alu_rot_out),
  .wen_z        (wen_z),
  .wen_ac       (wen_ac),
  .wen_cy       (wen_cy),
  .di_stb       (di_stb),
  .ei_stb       (ei_stb),
  .ack_stb      (ack_stb),
  .restore_en   (restore_en),
  .restore_byte (restore_byte),
  .flag_ie      (flag_ie),
  .flag_z       (flag_z),
  .flag_ac      (flag_ac),
  .flag_cy      (flag_cy)
);

// File: tb/cpu_status_flags_tb_top.sv
module cpu_status_flags_tb_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 22;

  // alu = {carry, half, rot_out, bit_in}; ctl = {wen_z, wen_ac, wen_cy, di, ei, ack, restore}
  typedef struct packed {
    logic [2:0] cls;
    logic [2:0] fn;
    logic [7:0] res;
    logic [3:0] alu;
    logic [6:0] ctl;
    logic [7:0] ldd;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 3'd0, 8'h00, 4'b0000, 7'b000_010_0, 8'h00, 8'h80, 4'd8},  // R8 EI
    '{3'd1, 3'd0, 8'h00, 4'b1100, 7'b111_000_0, 8'h00, 8'hD1, 4'd2},  // R2 R3 R4
    '{3'd1, 3'd0, 8'h5A, 4'b0000, 7'b111_000_0, 8'h00, 8'h80, 4'd4},  // R4
    '{3'd4, 3'd0, 8'h00, 4'b1100, 7'b111_000_0, 8'h00, 8'hC0, 4'd7},  // R7 logic keeps AC/CY
    '{3'd2, 3'd0, 8'h55, 4'b0010, 7'b111_000_0, 8'h00, 8'hC1, 4'd5},  // R5
    '{3'd3, 3'd1, 8'h00, 4'b0000, 7'b001_000_0, 8'h00, 8'hC0, 4'd6},  // R6 AND
    '{3'd3, 3'd2, 8'h00, 4'b0001, 7'b001_000_0, 8'h00, 8'hC1, 4'd6},  // R6 OR
    '{3'd3, 3'd3, 8'h00, 4'b0001, 7'b001_000_0, 8'h00, 8'hC0, 4'd6},  // R6 XOR
    '{3'd3, 3'd4, 8'h00, 4'b0000, 7'b001_000_0, 8'h00, 8'hC1, 4'd6},  // R6 SET
    '{3'd3, 3'd6, 8'h00, 4'b0000, 7'b001_000_0, 8'h00, 8'hC0, 4'd6},  // R6 CPL
    '{3'd3, 3'd0, 8'h00, 4'b0001, 7'b001_000_0, 8'h00, 8'hC1, 4'd6},  // R6 LOAD
    '{3'd3, 3'd7, 8'h00, 4'b0000, 7'b001_000_0, 8'h00, 8'hC1, 4'd6},  // R6 KEEP
    '{3'd3, 3'd5, 8'h00, 4'b0000, 7'b000_000_0, 8'h00, 8'hC1, 4'd7},  // R7 wen_cy low
    '{3'd1, 3'd0, 8'h01, 4'b1110, 7'b100_000_0, 8'h00, 8'h81, 4'd7},  // R7 only Z written
    '{3'd0, 3'd0, 8'h00, 4'b0000, 7'b000_110_0, 8'h00, 8'h01, 4'd8},  // R8 DI beats EI
    '{3'd0, 3'd0, 8'h00, 4'b0000, 7'b000_011_0, 8'h00, 8'h01, 4'd9},  // R9 ack beats EI
    '{3'd1, 3'd0, 8'h01, 4'b0000, 7'b111_000_1, 8'hFF, 8'hD1, 4'd11}, // R11 restore wins
    '{3'd0, 3'd0, 8'h00, 4'b0000, 7'b000_001_1, 8'h41, 8'h41, 4'd9},  // R9 ack beats restore
    '{3'd0, 3'd3, 8'h00, 4'b1111, 7'b111_000_0, 8'h00, 8'h41, 4'd7},  // R7 class none
    '{3'd7, 3'd3, 8'h00, 4'b1111, 7'b111_000_0, 8'h00, 8'h41, 4'd7},  // R7 unused class
    '{3'd0, 3'd0, 8'h00, 4'b0000, 7'b000_010_0, 8'h00, 8'hC1, 4'd8},  // R8 EI
    '{3'd0, 3'd0, 8'h00, 4'b0000, 7'b000_100_0, 8'h00, 8'h41, 4'd8}   // R8 DI
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_class, bit_fn;
  logic [7:0] alu_res, restore_byte;
  logic       alu_carry, alu_half, alu_rot_out, bit_in;
  logic       wen_z, wen_ac, wen_cy, di_stb, ei_stb, ack_stb, restore_en;
  logic       flag_ie, flag_z, flag_ac, flag_cy;
  logic [7:0] status_byte;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cpu_status_flags dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_class     (op_class),
    .bit_fn       (bit_fn),
    .alu_res      (alu_res),
    .alu_carry    (alu_carry),
    .alu_half     (alu_half),
    .alu_rot_out  (alu_rot_out),
    .bit_in       (bit_in),
    .wen_z        (wen_z),
    .wen_ac       (wen_ac),
    .wen_cy       (wen_cy),
    .di_stb       (di_stb),
    .ei_stb       (ei_stb),
    .ack_stb      (ack_stb),
    .restore_en   (restore_en),
    .restore_byte (restore_byte),
    .flag_ie      (flag_ie),
    .flag_z       (flag_z),
    .flag_ac      (flag_ac),
    .flag_cy      (flag_cy),
    .status_byte  (status_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_class = 3'd0; bit_fn = 3'd0; alu_res = 8'h00; restore_byte = 8'h00;
    {alu_carry, alu_half, alu_rot_out, bit_in} = 4'b0000;
    {wen_z, wen_ac, wen_cy, di_stb, ei_stb, ack_stb, restore_en} = 7'b0;
  endtask

  task automatic apply(input vec_t v);
    op_class = v.cls; bit_fn = v.fn; alu_res = v.res; restore_byte = v.ldd;
    {alu_carry, alu_half, alu_rot_out, bit_in} = v.alu;
    {wen_z, wen_ac, wen_cy, di_stb, ei_stb, ack_stb, restore_en} = v.ctl;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset byte", status_byte, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", status_byte, 8'h00);

    // table walk: drive at a falling edge, check at the next one
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      checks++;
      if (status_byte !== VECS[i].exp) begin
        failures++;
        $display("FAIL R%0d vec %0d status_byte actual=%02h expected=%02h",
                 VECS[i].req, i, status_byte, VECS[i].exp);
      end
      // R10: each flag output matches its byte position
      check("R10 flags vs layout", {flag_ie, flag_z, 1'b0, flag_ac, 3'b000, flag_cy}, VECS[i].exp);
    end
    idle_inputs();

    // R1: asynchronous clear in mid run
    @(negedge clk);
    #(CLK_P/4);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", status_byte, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 held after release", status_byte, 8'h00);

    // R8 operational again after reset
    ei_stb = 1'b1;
    @(negedge clk);
    ei_stb = 1'b0;
    check("R8 EI after reset", status_byte, 8'h80);

    // R9 lone acknowledge
    ack_stb = 1'b1;
    @(negedge clk);
    ack_stb = 1'b0;
    check("R9 ack alone", status_byte, 8'h00);

    // R3 borrow into bit 3 alone sets half carry only
    op_class = 3'd1; alu_res = 8'h0F; alu_half = 1'b1; wen_z = 1'b1; wen_ac = 1'b1; wen_cy = 1'b1;
    @(negedge clk);
    idle_inputs();
    check("R3 half carry alone", status_byte, 8'h10);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule